// File: doc/BRIEF.md
# Flash ready/busy wait controller

After a command sequence has been sent to a raw flash device, this block waits until the device is ready again. A start request carries a wait kind and is sampled together with a configuration flag saying whether a dedicated ready/busy pin is wired. When the pin exists, the block samples it. When it does not, the block asks a bus sequencer for status-byte reads and tests the ready bit of each byte. The block never generates data transfers or command sequences itself. Its only requests to the sequencer are "send the status command" and "read one status byte", made over a request/acknowledge handshake.

Every kind that polls is guarded by a timeout. Timeouts and delays are given in physical units and converted to clock cycles through a clock-frequency parameter, so a bench can scale them down. When a timeout expires, the block does not hang: it finishes with a timeout flag. Several kinds get extra treatment. A reset issued with no pin waits a fixed chip delay, sends a status command, and then polls with a shorter timeout. Other waiting commands with no pin simply sit out the chip delay. The program/erase completion kind reads one last status byte and flags a warning if that byte is not ready. The result is presented with a one-cycle done pulse and is held until the next accepted start.

Top module: `nand_rb_wait`

## Requirements
- R1: After reset, busy_o, done_o, st_req_o, timeout_o and warn_o are 0 and status_o is 0.
- R2: start_i is accepted only while busy_o is 0. A start arriving while a wait is in progress has no effect: there is no extra done, no status traffic, and the running wait keeps its kind. Kind code 0 (no wait) produces done_o in the cycle after the start, with no status traffic.
- R3: Kind code 1 (generic wait) with rb_present_i=1 first waits the pre-poll delay (PRE_NS rounded up to whole cycles, at least one). It then samples rb_ready_i, where 1 means ready, and makes no status requests. done_o follows within two cycles of the sample that sees the device ready.
- R4: Kind code 1 with rb_present_i=0 waits only the chip delay and then finishes, with no status requests. The chip delay is CHIP_DELAY_US microseconds, or 20 us when the parameter is 0, rounded up to whole cycles.
- R5: Kind code 2 (reset) with rb_present_i=0 waits the chip delay, makes one status-command request (st_op_o=1), and then makes status-read requests (st_op_o=0) until a byte has bit RDY_BIT (default 6) set. status_o holds the last byte read.
- R6: In the reset status-poll path, the poll gives up after RST_WAIT_MS (default 250 ms) of cycles. The block then finishes with timeout_o=1.
- R7: Every other poll gives up after WAIT_MS (default 400 ms) of cycles, pin or status reads alike. The block then finishes with timeout_o=1.
- R8: Kind code 3 (program/erase completion) waits the pre-poll delay, makes one status-command request, and polls the pin or status reads. It then makes exactly one more status read. status_o is that byte, and warn_o=1 exactly when its ready bit is clear.
- R9: Once raised, st_req_o stays high with st_op_o unchanged until a cycle with st_ack_i=1.
- R10: done_o is a one-cycle pulse, and busy_o falls in the same cycle. status_o, timeout_o and warn_o stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a wait (accepted while idle) |
| kind_i | input | 2 | Wait kind: 0 none, 1 generic, 2 reset, 3 program/erase completion |
| rb_present_i | input | 1 | 1 when a ready/busy pin is wired |
| rb_ready_i | input | 1 | Ready/busy pin, 1 = ready |
| st_req_o | output | 1 | Request to the bus sequencer |
| st_op_o | output | 1 | Request type: 0 read status byte, 1 send status command |
| st_ack_i | input | 1 | One-cycle acknowledge of the pending request |
| st_data_i | input | 8 | Status byte, valid with st_ack_i on a read |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Last status byte read in this wait (0 if none) |
| timeout_o | output | 1 | The poll expired without seeing ready |
| warn_o | output | 1 | Program/erase final byte had ready bit clear |

## Verification
The assertions take three things for granted. The sequencer raises st_ack_i only while st_req_o is high and holds it for a single cycle. st_data_i is meaningful only together with such an acknowledge. rb_present_i is the same value the wait was started with. The bench keeps within these limits through a responder that acknowledges only a pending request, after a programmable latency and for one cycle. It drops the acknowledge before looking at the next request, and it changes the pin configuration only between waits. The bench scales the clock-frequency parameter down so that the 250 ms and 400 ms windows fit into a short run.

// File: rtl/nrbw_pkg.sv
package nrbw_pkg;

    typedef enum logic [1:0] {
        KIND_NOWAIT    = 2'd0,
        KIND_GENERIC   = 2'd1,
        KIND_RESET     = 2'd2,
        KIND_PROGERASE = 2'd3
    } wait_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DELAY,
        PH_STCMD,
        PH_POLL,
        PH_FINAL
    } phase_e;

    localparam logic OP_READ = 1'b0;
    localparam logic OP_CMD  = 1'b1;

    typedef struct packed {
        phase_e     phase;
        phase_e     after;
        wait_kind_e kind;
        logic       pin;
        logic       req;
        logic       op;
        logic       done;
        logic       tmo;
        logic       warn;
        logic [7:0] status;
    } wait_regs_t;

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nrbw_downcnt.sv
module nrbw_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (en_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait
    import nrbw_pkg::*;
#(
    parameter int unsigned CLK_KHZ       = 50000,
    parameter int unsigned WAIT_MS       = 400,
    parameter int unsigned RST_WAIT_MS   = 250,
    parameter int unsigned CHIP_DELAY_US = 0,
    parameter int unsigned PRE_NS        = 100,
    parameter int unsigned RDY_BIT       = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] kind_i,
    input  logic       rb_present_i,
    input  logic       rb_ready_i,
    output logic       st_req_o,
    output logic       st_op_o,
    input  logic       st_ack_i,
    input  logic [7:0] st_data_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] status_o,
    output logic       timeout_o,
    output logic       warn_o
);
    localparam int unsigned CHIP_US  = (CHIP_DELAY_US == 0) ? 20 : CHIP_DELAY_US;
    localparam int unsigned CHIP_CYC = at_least_one(ceil_div(CLK_KHZ * CHIP_US, 1000));
    localparam int unsigned PRE_CYC  = at_least_one(ceil_div(CLK_KHZ * PRE_NS, 1000000));
    localparam int unsigned WAIT_CYC = at_least_one(CLK_KHZ * WAIT_MS);
    localparam int unsigned RST_CYC  = at_least_one(CLK_KHZ * RST_WAIT_MS);
    localparam int unsigned DLY_MAX  = max_u(CHIP_CYC, PRE_CYC);
    localparam int unsigned TMO_MAX  = max_u(WAIT_CYC, RST_CYC);
    localparam int          DLY_W    = $clog2(DLY_MAX + 1);
    localparam int          TMO_W    = $clog2(TMO_MAX + 1);

    wait_regs_t r_d, r_q;

    logic             dly_load, dly_zero;
    logic [DLY_W-1:0] dly_val;
    logic             tmo_load, tmo_zero;
    logic [TMO_W-1:0] tmo_val;

    nrbw_downcnt #(.W(DLY_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dly_load),
        .en_i      (r_q.phase == PH_DELAY),
        .load_val_i(dly_val),
        .zero_o    (dly_zero)
    );

    nrbw_downcnt #(.W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmo_load),
        .en_i      (r_q.phase == PH_POLL),
        .load_val_i(tmo_val),
        .zero_o    (tmo_zero)
    );

    always_comb begin
        logic leave_poll;
        r_d        = r_q;
        r_d.done   = 1'b0;
        dly_load   = 1'b0;
        dly_val    = DLY_W'(PRE_CYC - 1);
        tmo_load   = 1'b0;
        tmo_val    = (r_q.kind == KIND_RESET && !r_q.pin) ? TMO_W'(RST_CYC - 1)
                                                          : TMO_W'(WAIT_CYC - 1);
        leave_poll = 1'b0;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    r_d.kind   = wait_kind_e'(kind_i);
                    r_d.pin    = rb_present_i;
                    r_d.status = '0;
                    r_d.tmo    = 1'b0;
                    r_d.warn   = 1'b0;
                    if (wait_kind_e'(kind_i) == KIND_NOWAIT) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.phase = PH_DELAY;
                        dly_load  = 1'b1;
                        if (wait_kind_e'(kind_i) == KIND_PROGERASE) begin
                            r_d.after = PH_STCMD;
                        end else if (rb_present_i) begin
                            r_d.after = PH_POLL;
                        end else begin
                            dly_val   = DLY_W'(CHIP_CYC - 1);
                            r_d.after = (wait_kind_e'(kind_i) == KIND_RESET) ? PH_STCMD : PH_IDLE;
                        end
                    end
                end
            end
            PH_DELAY: begin
                if (dly_zero) begin
                    r_d.phase = r_q.after;
                    if (r_q.after == PH_IDLE) begin
                        r_d.done = 1'b1;
                    end else if (r_q.after == PH_STCMD) begin
                        r_d.req = 1'b1;
                        r_d.op  = OP_CMD;
                    end else begin
                        tmo_load = 1'b1;
                        r_d.req  = !r_q.pin;
                        r_d.op   = OP_READ;
                    end
                end
            end
            PH_STCMD: begin
                if (st_ack_i) begin
                    r_d.phase = PH_POLL;
                    tmo_load  = 1'b1;
                    r_d.req   = !r_q.pin;
                    r_d.op    = OP_READ;
                end
            end
            PH_POLL: begin
                if (r_q.pin) begin
                    if (rb_ready_i) begin
                        leave_poll = 1'b1;
                    end else if (tmo_zero) begin
                        r_d.tmo    = 1'b1;
                        leave_poll = 1'b1;
                    end
                end else if (st_ack_i) begin
                    r_d.status = st_data_i;
                    if (st_data_i[RDY_BIT]) begin
                        leave_poll = 1'b1;
                    end else if (tmo_zero) begin
                        r_d.tmo    = 1'b1;
                        leave_poll = 1'b1;
                    end
                end
                if (leave_poll) begin
                    if (r_q.kind == KIND_PROGERASE) begin
                        r_d.phase = PH_FINAL;
                        r_d.req   = 1'b1;
                        r_d.op    = OP_READ;
                    end else begin
                        r_d.phase = PH_IDLE;
                        r_d.req   = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
            end
            PH_FINAL: begin
                if (st_ack_i) begin
                    r_d.status = st_data_i;
                    r_d.warn   = !st_data_i[RDY_BIT];
                    r_d.req    = 1'b0;
                    r_d.phase  = PH_IDLE;
                    r_d.done   = 1'b1;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, after: PH_IDLE, kind: KIND_NOWAIT,
                     pin: 1'b0, req: 1'b0, op: OP_READ, done: 1'b0,
                     tmo: 1'b0, warn: 1'b0, status: 8'h00};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_req_o  = r_q.req;
    assign st_op_o   = r_q.op;
    assign busy_o    = (r_q.phase != PH_IDLE);
    assign done_o    = r_q.done;
    assign status_o  = r_q.status;
    assign timeout_o = r_q.tmo;
    assign warn_o    = r_q.warn;

    // R9: a pending request keeps its type until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && !st_ack_i) |=> (st_req_o && $stable(st_op_o)));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: a wait only ends through a done pulse, so a start cannot cut it short
    p_busy_ends_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R2: a wait only begins from an accepted start
    p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R3: the pin-polled generic wait never talks to the sequencer
    p_pin_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && r_q.pin && r_q.kind == KIND_GENERIC) |-> !st_req_o);

    // R8: the warning only accompanies a not-ready final byte
    p_warn_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && warn_o) |-> !status_o[RDY_BIT]);

endmodule

// File: tb/nand_rb_wait_bench.sv
`timescale 1ns/1ps
module nand_rb_wait_bench;

    localparam int unsigned KHZ      = 50;
    localparam int unsigned CHIP_CYC = 10;     // 200 us at 50 kHz
    localparam int unsigned PRE_CYC  = 1;      // 100 ns rounded up
    localparam int unsigned WAIT_CYC = 20000;  // 400 ms at 50 kHz
    localparam int unsigned RST_CYC  = 12500;  // 250 ms at 50 kHz
    localparam int unsigned DFLT_CYC = 20;     // 20 us at 1 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] kind = 2'd0;
    logic       rbp = 1'b0;
    logic       rby = 1'b0;
    logic       ack = 1'b0;
    logic [7:0] rdata = 8'h00;
    logic       st_req_o, st_op_o, busy_o, done_o, timeout_o, warn_o;
    logic [7:0] status_o;

    logic       start2 = 1'b0;
    logic       req2, op2, busy2, done2, tmo2, warn2;
    logic [7:0] stat2;

    int n_chk = 0;
    int n_bad = 0;
    int n_cmd = 0;
    int n_read = 0;
    int busy_reads = 0;
    int resp_lat = 0;
    int wcnt = 0;
    int op_glitch = 0;
    bit seen = 0;
    logic op_seen = 1'b0;

    always #10 clk = ~clk;

    nand_rb_wait #(.CLK_KHZ(KHZ), .CHIP_DELAY_US(200)) u_nand_rb_wait (
        .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
        .rb_present_i(rbp), .rb_ready_i(rby), .st_req_o(st_req_o),
        .st_op_o(st_op_o), .st_ack_i(ack), .st_data_i(rdata),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .timeout_o(timeout_o), .warn_o(warn_o)
    );

    nand_rb_wait #(.CLK_KHZ(1000), .CHIP_DELAY_US(0)) u_nand_rb_wait_dflt (
        .clk(clk), .rst_n(rst_n), .start_i(start2), .kind_i(2'd1),
        .rb_present_i(1'b0), .rb_ready_i(1'b0), .st_req_o(req2),
        .st_op_o(op2), .st_ack_i(1'b0), .st_data_i(8'h00),
        .busy_o(busy2), .done_o(done2), .status_o(stat2),
        .timeout_o(tmo2), .warn_o(warn2)
    );

    // sequencer model: acknowledges only a pending request, for one cycle
    always @(negedge clk) begin
        if (ack) begin
            ack = 1'b0;
        end else if (st_req_o) begin
            if (!seen) begin
                seen = 1;
                op_seen = st_op_o;
                wcnt = 0;
            end else if (st_op_o != op_seen) begin
                op_glitch++;
            end
            if (wcnt >= resp_lat) begin
                ack = 1'b1;
                seen = 0;
                if (st_op_o) begin
                    n_cmd++;
                    rdata = 8'h00;
                end else begin
                    rdata = (n_read < busy_reads) ? 8'h80 : 8'hC0;
                    n_read++;
                end
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_traffic(input int busy_n, input int lat);
        n_cmd = 0;
        n_read = 0;
        busy_reads = busy_n;
        resp_lat = lat;
        op_glitch = 0;
    endtask

    task automatic kick(input logic [1:0] k, input logic pin, output int cyc);
        @(negedge clk);
        start = 1'b1;
        kind = k;
        rbp = pin;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset_state();
        chk(busy_o == 0 && done_o == 0, "R1 busy/done", int'({busy_o, done_o}), 0);
        chk(st_req_o == 0, "R1 request", int'(st_req_o), 0);
        chk(status_o == 0 && timeout_o == 0 && warn_o == 0, "R1 result",
            int'({status_o, timeout_o, warn_o}), 0);
    endtask

    task automatic t_nowait();
        int cyc;
        clr_traffic(0, 0);
        kick(2'd0, 1'b0, cyc);
        chk(cyc == 1, "R2 no-wait latency", cyc, 1);
        chk(n_cmd + n_read == 0, "R2 no-wait traffic", n_cmd + n_read, 0);
    endtask

    task automatic t_pin_generic();
        int cyc;
        clr_traffic(0, 0);
        rby = 1'b1;
        kick(2'd1, 1'b1, cyc);
        chk(cyc >= PRE_CYC + 1 && cyc <= PRE_CYC + 3, "R3 pin ready latency", cyc, PRE_CYC + 2);
        chk(n_cmd + n_read == 0, "R3 no status traffic", n_cmd + n_read, 0);
        chk(timeout_o == 0, "R3 no timeout", int'(timeout_o), 0);
    endtask

    task automatic t_nopin_generic();
        int cyc;
        clr_traffic(0, 0);
        kick(2'd1, 1'b0, cyc);
        chk(cyc >= CHIP_CYC + 1 && cyc <= CHIP_CYC + 2, "R4 chip delay", cyc, CHIP_CYC + 1);
        chk(n_cmd + n_read == 0, "R4 no polling", n_cmd + n_read, 0);
    endtask

    task automatic t_default_delay();
        int cyc;
        @(negedge clk);
        start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        cyc = 1;
        while (!done2 && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc >= DFLT_CYC + 1 && cyc <= DFLT_CYC + 2, "R4 default 20us delay", cyc, DFLT_CYC + 1);
    endtask

    task automatic t_reset_nopin();
        int cyc;
        clr_traffic(2, 3);
        kick(2'd2, 1'b0, cyc);
        chk(n_cmd == 1, "R5 one status command", n_cmd, 1);
        chk(n_read == 3, "R5 reads until ready", n_read, 3);
        chk(status_o == 8'hC0, "R5 last byte", int'(status_o), 'hC0);
        chk(timeout_o == 0 && cyc > CHIP_CYC, "R5 no timeout after chip delay", cyc, CHIP_CYC + 1);
        chk(op_glitch == 0, "R9 request held with stable op", op_glitch, 0);
    endtask

    task automatic t_reset_timeout();
        int cyc;
        clr_traffic(1000000, 0);
        kick(2'd2, 1'b0, cyc);
        chk(timeout_o == 1, "R6 reset poll timeout flag", int'(timeout_o), 1);
        chk(cyc >= RST_CYC && cyc <= RST_CYC + 30, "R6 reset timeout window", cyc, RST_CYC);
        chk(warn_o == 0 && status_o == 8'h80, "R6 result byte", int'({warn_o, status_o}), 'h80);
    endtask

    task automatic t_pin_timeout();
        int cyc;
        clr_traffic(0, 0);
        rby = 1'b0;
        kick(2'd1, 1'b1, cyc);
        chk(timeout_o == 1, "R7 pin timeout flag", int'(timeout_o), 1);
        chk(cyc >= WAIT_CYC && cyc <= WAIT_CYC + PRE_CYC + 4, "R7 general timeout window", cyc, WAIT_CYC);
    endtask

    task automatic t_progerase_reads();
        int cyc;
        clr_traffic(3, 1);
        kick(2'd3, 1'b0, cyc);
        chk(n_cmd == 1, "R8 status command", n_cmd, 1);
        chk(n_read == 5, "R8 poll reads plus one final read", n_read, 5);
        chk(status_o == 8'hC0 && warn_o == 0, "R8 ready final byte", int'({warn_o, status_o}), 'hC0);
        repeat (3) @(negedge clk);
        chk(done_o == 0 && busy_o == 0, "R10 single done pulse", int'({done_o, busy_o}), 0);
        chk(status_o == 8'hC0 && timeout_o == 0, "R10 result held", int'(status_o), 'hC0);
    endtask

    task automatic t_progerase_pin_warn();
        int cyc;
        clr_traffic(1000000, 0);
        rby = 1'b0;
        fork
            begin
                repeat (20) @(negedge clk);
                rby = 1'b1;
            end
        join_none
        kick(2'd3, 1'b1, cyc);
        chk(n_cmd == 1 && n_read == 1, "R8 pin poll, one final read", n_read, 1);
        chk(warn_o == 1, "R8 warning on busy final byte", int'(warn_o), 1);
        chk(timeout_o == 0 && status_o == 8'h80, "R8 final byte returned", int'(status_o), 'h80);
    endtask

    task automatic t_start_ignored();
        int dones;
        clr_traffic(0, 0);
        rby = 1'b0;
        @(negedge clk);
        start = 1'b1;
        kind = 2'd1;
        rbp = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1;
        kind = 2'd2;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        repeat (5) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        chk(busy_o == 1 && dones == 0, "R2 busy start ignored", dones, 0);
        rby = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        chk(dones == 1, "R2 exactly one completion", dones, 1);
        chk(n_cmd + n_read == 0 && timeout_o == 0, "R2 no reset flow started", n_cmd + n_read, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_nowait();
        t_pin_generic();
        t_nopin_generic();
        t_default_delay();
        t_reset_nopin();
        t_progerase_reads();
        t_progerase_pin_warn();
        t_start_ignored();
        t_reset_timeout();
        t_pin_timeout();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule